// File: doc/BRIEF.md
# DS3 C-bit serial access port

This block gives external logic serial access to the 21 C-bits of each DS3 M-frame while the line runs in C-bit parity mode. Framing recovery and parity generation are handled elsewhere. The block is told where each M-frame starts and when a C-bit occupies the current bit slot. It receives one strobe pair for the receive stream and another for the transmit stream.

On the receive side, the block collects all 21 received C-bits. When the next M-frame starts, it sends 14 of them out as a serial burst, with a port clock, a framing pulse and a data-link marker. On the transmit side, each M-frame start opens a burst of 13 or 14 port clocks, chosen by a mode input. The external source supplies one C-bit per clock. The collected bits replace the stream's C-bit slots in the following M-frame. The three spare C-bits are driven to 1, and every other bit of the stream passes through with one register of delay.

C-bits are numbered C1 to C21 in the order of their strobes after a frame strobe. The slot set carried on both ports is C1, C3, C4, C5, C10 to C17, C19 and C20, sent in ascending order. The data-link slots are C13 to C15, and the spare slots are C6, C18 and C21.

Top module: `cbit_port`

## Requirements
- R1: After each rx_fs, the receive port sends 14 bits in ascending slot order (C1, C3, C4, C5, C10..C17, C19, C20). These are the C-bits captured in the preceding M-frame, where the k-th rx_cs strobe after rx_fs carries C-bit k. Before any frame has been captured, the bits are 0.
- R2: Each serial bit on either port lasts two clk cycles, with the port clock low in the first and high in the second. Receive data changes only when the port clock falls and is stable while it is high.
- R3: On each port, the framing pulse is high for exactly the two cycles of the first bit of a burst and low at all other times.
- R4: A data-link marker is high during the bits carrying C13, C14 or C15 when dl_en was high on the previous cycle, and low otherwise. There is one marker for each port.
- R5: When tx_full is 1 at tx_fs, the transmit port sends 14 clocks and samples txp_dat on each rising port clock. The sampled bits replace slots C1, C3, C4, C5, C10..C17, C19 and C20, in that order, on tx_bit_out during the next M-frame.
- R6: When tx_full is 0 at tx_fs, the burst has 13 clocks whose bits replace C3, C4, C5, C10..C17, C19 and C20 in the next M-frame. In that frame, C1 passes the stream bit through.
- R7: On tx_bit_out, C6, C18 and C21 are always 1, one cycle after their tx_cs strobe.
- R8: Every other stream bit, including C2 and C7..C9 and all non-C-bit positions, appears on tx_bit_out one cycle after it is on tx_bit_in.
- R9: Each transmit port clock pulse is high for exactly one cycle, and a burst has exactly as many pulses as R5 or R6 requires.
- R10: A synchronous active-high reset drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_en | input | 1 | Enables both data-link markers |
| rx_fs | input | 1 | Receive M-frame start strobe |
| rx_cs | input | 1 | Receive C-bit slot strobe |
| rx_bit | input | 1 | Received stream bit |
| rxp_clk | output | 1 | Receive port clock |
| rxp_dat | output | 1 | Receive port serial data |
| rxp_fp | output | 1 | Receive port framing pulse |
| rxp_dl | output | 1 | Receive port data-link marker |
| tx_fs | input | 1 | Transmit M-frame start strobe |
| tx_cs | input | 1 | Transmit C-bit slot strobe |
| tx_bit_in | input | 1 | Outgoing stream bit before insertion |
| tx_bit_out | output | 1 | Outgoing stream bit after insertion |
| tx_full | input | 1 | 1 selects 14-bit transmit bursts, 0 selects 13 |
| txp_dat | input | 1 | Transmit port serial data |
| txp_clk | output | 1 | Transmit port clock |
| txp_fp | output | 1 | Transmit port framing pulse |
| txp_dl | output | 1 | Transmit port data-link marker |

## Verification
The assertions assume three things about the inputs:
- A frame strobe never shares a cycle with a C-bit strobe.
- At most 21 C-bit strobes arrive per frame.
- A burst of at most 29 cycles has ended before the next frame strobe.

They also assume that dl_en and tx_full change only together with a frame strobe. The stimulus keeps within these limits by building each M-frame from one strobe cycle and 21 C-bit strobes, each preceded by one to three random plain bits, followed by a short tail. Every frame is therefore longer than any burst. Slot contents, mode and marker enable are random or set to all-zero, all-one and alternating patterns.

// File: rtl/cbport_pkg.sv
package cbport_pkg;
  localparam int NCB  = 21;
  localparam int SLW  = $clog2(NCB);
  localparam int CNTW = $clog2(NCB + 1);

  typedef logic [NCB-1:0] cmask_t;
  typedef logic [SLW-1:0] slot_t;

  // slot number of the n-th set bit of m, counting from bit 0
  function automatic slot_t nth_set(cmask_t m, slot_t n);
    slot_t c;
    nth_set = '0;
    c = '0;
    for (int b = 0; b < NCB; b++) begin
      if (m[b]) begin
        if (c == n) nth_set = slot_t'(b);
        c = c + slot_t'(1);
      end
    end
  endfunction
endpackage

// File: rtl/cbit_burst_seq.sv
module cbit_burst_seq #(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IDXW-1:0] len,
  output logic            active,
  output logic            hi,
  output logic [IDXW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hi     <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      hi     <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      if (!hi) begin
        hi <= 1'b1;
      end else begin
        hi <= 1'b0;
        if (idx == len - IDXW'(1)) active <= 1'b0;
        else                       idx    <= idx + IDXW'(1);
      end
    end
  end

  // R9
  hi_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (active && hi) |=> !hi);
endmodule

// File: rtl/cbit_rx_ser.sv
module cbit_rx_ser import cbport_pkg::*; #(
  parameter cmask_t TAKE = 21'h0DFE1D,
  parameter cmask_t DLM  = 21'h007000
) (
  input  logic clk,
  input  logic rst,
  input  logic fs,
  input  logic cs,
  input  logic din,
  input  logic dl_en,
  output logic sclk,
  output logic sdat,
  output logic sfp,
  output logic sdl
);
  localparam int NSER = $countones(TAKE);
  localparam int IDXW = $clog2(NSER + 1);

  logic [CNTW-1:0] cidx;
  cmask_t          cap, snap;
  logic            act, hi;
  logic [IDXW-1:0] idx;
  slot_t           slot;

  cbit_burst_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst(rst), .start(fs), .len(IDXW'(NSER)),
    .active(act), .hi(hi), .idx(idx)
  );

  assign slot = nth_set(TAKE, slot_t'(idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      cidx <= '0;
      cap  <= '0;
      snap <= '0;
    end else if (fs) begin
      cidx <= '0;
      snap <= cap;
    end else if (cs && cidx < CNTW'(NCB)) begin
      cap[slot_t'(cidx)] <= din;
      cidx               <= cidx + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      sdat <= 1'b0;
      sfp  <= 1'b0;
      sdl  <= 1'b0;
    end else begin
      sclk <= act & hi;
      sdat <= act & snap[slot];
      sfp  <= act & (idx == '0);
      sdl  <= act & dl_en & DLM[slot];
    end
  end

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdat));
  // R3
  rx_fp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sfp) |-> !sclk);
  // R4
  rx_dl_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dl_en) |-> !sdl);
endmodule

// File: rtl/cbit_tx_merge.sv
module cbit_tx_merge import cbport_pkg::*; #(
  parameter cmask_t TAKE  = 21'h0DFE1D,
  parameter cmask_t DROP  = 21'h000001,
  parameter cmask_t SPARE = 21'h120020,
  parameter cmask_t DLM   = 21'h007000
) (
  input  logic clk,
  input  logic rst,
  input  logic fs,
  input  logic cs,
  input  logic din,
  input  logic full,
  input  logic dl_en,
  input  logic sdi,
  output logic sclk,
  output logic sfp,
  output logic sdl,
  output logic dout
);
  localparam cmask_t TAKE_S = TAKE & ~DROP;
  localparam int     NFULL  = $countones(TAKE);
  localparam int     NSHORT = $countones(TAKE_S);
  localparam int     IDXW   = $clog2(NFULL + 1);

  logic            bm;
  cmask_t          bmask, col, apply, amask;
  logic [CNTW-1:0] ccnt;
  logic            act, hi, ins;
  logic [IDXW-1:0] idx;
  slot_t           slot, cslot;

  assign bmask = bm ? TAKE : TAKE_S;
  assign slot  = nth_set(bmask, slot_t'(idx));
  assign cslot = slot_t'(ccnt);
  assign ins   = cs && !fs && (ccnt < CNTW'(NCB));

  cbit_burst_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst(rst), .start(fs),
    .len(bm ? IDXW'(NFULL) : IDXW'(NSHORT)),
    .active(act), .hi(hi), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bm    <= 1'b0;
      col   <= '0;
      apply <= '0;
      amask <= '0;
      ccnt  <= '0;
    end else begin
      if (fs) begin
        bm    <= full;
        apply <= col;
        amask <= bmask;
        ccnt  <= '0;
      end else if (ins) begin
        ccnt <= ccnt + CNTW'(1);
      end
      if (act && hi) col[slot] <= sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      sfp  <= 1'b0;
      sdl  <= 1'b0;
      dout <= 1'b0;
    end else begin
      sclk <= act & hi;
      sfp  <= act & (idx == '0);
      sdl  <= act & dl_en & DLM[slot];
      if (ins && amask[cslot])      dout <= apply[cslot];
      else if (ins && SPARE[cslot]) dout <= 1'b1;
      else                          dout <= din;
    end
  end

  // R8
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (dout == $past(din)));
  // R7
  spare_chk: assert property (@(posedge clk) disable iff (rst)
    (ins && SPARE[cslot] && !amask[cslot]) |=> dout);
  // R3
  tx_fp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sfp) |-> !sclk);
  // R4
  tx_dl_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dl_en) |-> !sdl);
endmodule

// File: rtl/cbit_port.sv
module cbit_port import cbport_pkg::*; #(
  parameter cmask_t TAKE_MASK  = 21'h0DFE1D,
  parameter cmask_t DROP_MASK  = 21'h000001,
  parameter cmask_t SPARE_MASK = 21'h120020,
  parameter cmask_t DL_MASK    = 21'h007000
) (
  input  logic clk,
  input  logic rst,
  input  logic dl_en,
  input  logic rx_fs,
  input  logic rx_cs,
  input  logic rx_bit,
  output logic rxp_clk,
  output logic rxp_dat,
  output logic rxp_fp,
  output logic rxp_dl,
  input  logic tx_fs,
  input  logic tx_cs,
  input  logic tx_bit_in,
  output logic tx_bit_out,
  input  logic tx_full,
  input  logic txp_dat,
  output logic txp_clk,
  output logic txp_fp,
  output logic txp_dl
);
  cbit_rx_ser #(.TAKE(TAKE_MASK), .DLM(DL_MASK)) u_rx (
    .clk(clk), .rst(rst), .fs(rx_fs), .cs(rx_cs), .din(rx_bit),
    .dl_en(dl_en), .sclk(rxp_clk), .sdat(rxp_dat), .sfp(rxp_fp),
    .sdl(rxp_dl)
  );

  cbit_tx_merge #(.TAKE(TAKE_MASK), .DROP(DROP_MASK),
                  .SPARE(SPARE_MASK), .DLM(DL_MASK)) u_tx (
    .clk(clk), .rst(rst), .fs(tx_fs), .cs(tx_cs), .din(tx_bit_in),
    .full(tx_full), .dl_en(dl_en), .sdi(txp_dat), .sclk(txp_clk),
    .sfp(txp_fp), .sdl(txp_dl), .dout(tx_bit_out)
  );

  // R10
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> !(rxp_clk | rxp_dat | rxp_fp | rxp_dl |
                     txp_clk | txp_fp | txp_dl | tx_bit_out));
endmodule

// File: tb/sim_cbit_port.sv
module sim_cbit_port;
  localparam logic [20:0] TAKE   = 21'h0DFE1D;
  localparam logic [20:0] TAKE13 = 21'h0DFE1C;
  localparam logic [20:0] SPARE  = 21'h120020;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, dl_en = 1'b0;
  logic rx_fs = 1'b0, rx_cs = 1'b0, rx_bit = 1'b0;
  logic tx_fs = 1'b0, tx_cs = 1'b0, tx_bit_in = 1'b0, tx_full = 1'b0, txp_dat = 1'b0;
  logic rxp_clk, rxp_dat, rxp_fp, rxp_dl, tx_bit_out, txp_clk, txp_fp, txp_dl;

  cbit_port u0 (
    .clk(clk), .rst(rst), .dl_en(dl_en), .rx_fs(rx_fs), .rx_cs(rx_cs),
    .rx_bit(rx_bit), .rxp_clk(rxp_clk), .rxp_dat(rxp_dat), .rxp_fp(rxp_fp),
    .rxp_dl(rxp_dl), .tx_fs(tx_fs), .tx_cs(tx_cs), .tx_bit_in(tx_bit_in),
    .tx_bit_out(tx_bit_out), .tx_full(tx_full), .txp_dat(txp_dat),
    .txp_clk(txp_clk), .txp_fp(txp_fp), .txp_dl(txp_dl)
  );

  int checks = 0, fails = 0;
  logic [20:0] rx_cur = '0, rx_prev = '0, col_m = '0, apply_m = '0, amask_m = '0, tx_ser = '0;
  bit bm_m = 1'b0, first = 1'b1, tx_chk_en = 1'b0;
  int rk = 0, rx_cnt = 0, rx_fph = 0, tk = 0, tx_cnt = 0, tx_fph = 0;
  logic prev_rclk = 1'b0, prev_rdat = 1'b0, prev_tclk = 1'b0, prev_tfp = 1'b0, exp_tx = 1'b0;
  string exp_req = "R8";

  function automatic int nth(logic [20:0] m, int n);
    int c = 0;
    nth = 0;
    for (int b = 0; b < 21; b++)
      if (m[b]) begin
        if (c == n) nth = b;
        c++;
      end
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    int s;
    @(negedge clk);
    // receive port
    if (rxp_clk && !prev_rclk) begin
      if (rxp_fp) rk = 0; else rk++;
      rx_cnt++;
      s = nth(TAKE, rk);
      chk(rxp_dat === rx_prev[s], "R1 rx bit", int'(rxp_dat), int'(rx_prev[s]));
      chk(rxp_dat === prev_rdat, "R2 rx data held", int'(rxp_dat), int'(prev_rdat));
      chk(rxp_dl === (dl_en && s >= 12 && s <= 14), "R4 rx marker", int'(rxp_dl),
          int'(dl_en && s >= 12 && s <= 14));
    end
    if (rxp_fp) rx_fph++;
    prev_rclk = rxp_clk;
    prev_rdat = rxp_dat;
    // transmit port
    if (txp_clk && !prev_tclk) begin
      tx_cnt++;
      s = nth(bm_m ? TAKE : TAKE13, tk);
      col_m[s] = txp_dat;
      chk(txp_dl === (dl_en && s >= 12 && s <= 14), "R4 tx marker", int'(txp_dl),
          int'(dl_en && s >= 12 && s <= 14));
    end
    if (txp_fp && !txp_clk && !prev_tfp) begin
      tk = 0;
      txp_dat = tx_ser[0];
    end else if (!txp_clk && prev_tclk) begin
      tk++;
      if (tk < 21) txp_dat = tx_ser[tk];
    end
    if (txp_fp) tx_fph++;
    prev_tclk = txp_clk;
    prev_tfp  = txp_fp;
    if (tx_chk_en)
      chk(tx_bit_out === exp_tx, exp_req, int'(tx_bit_out), int'(exp_tx));
  endtask

  task automatic frame(input logic [20:0] rbits, input bit mode, input bit dl);
    bit pm;
    if (!first) begin
      chk(rx_cnt == 14, "R1 rx burst length", rx_cnt, 14);
      chk(rx_fph == 2, "R3 rx framing cycles", rx_fph, 2);
      chk(tx_cnt == (bm_m ? 14 : 13), "R9 tx pulse count", tx_cnt, bm_m ? 14 : 13);
      chk(tx_fph == 2, "R3 tx framing cycles", tx_fph, 2);
    end
    first = 1'b0;
    rx_cnt = 0; rx_fph = 0; tx_cnt = 0; tx_fph = 0;
    rx_prev = rx_cur;
    apply_m = col_m;
    pm = bm_m;
    amask_m = bm_m ? TAKE : TAKE13;
    bm_m = mode;
    tx_ser = 21'($urandom);
    rx_fs = 1'b1; tx_fs = 1'b1; tx_full = mode; dl_en = dl;
    tx_bit_in = 1'($urandom); exp_tx = tx_bit_in; exp_req = "R8 frame cycle";
    step();
    rx_fs = 1'b0; tx_fs = 1'b0;
    for (int c = 0; c < 21; c++) begin
      repeat (1 + $urandom_range(2)) begin
        rx_bit = 1'($urandom); tx_bit_in = 1'($urandom);
        exp_tx = tx_bit_in; exp_req = "R8 plain bit";
        step();
      end
      rx_cs = 1'b1; rx_bit = rbits[c]; tx_cs = 1'b1; tx_bit_in = 1'($urandom);
      if (amask_m[c]) begin
        exp_tx = apply_m[c]; exp_req = pm ? "R5 inserted" : "R6 inserted";
      end else if (SPARE[c]) begin
        exp_tx = 1'b1; exp_req = "R7 spare";
      end else begin
        exp_tx = tx_bit_in; exp_req = (c == 0) ? "R6 C1 passes" : "R8 C-bit passes";
      end
      step();
      rx_cur[c] = rbits[c];
      rx_cs = 1'b0; tx_cs = 1'b0;
    end
    repeat (4) begin
      tx_bit_in = 1'($urandom); exp_tx = tx_bit_in; exp_req = "R8 tail";
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10
    chk({rxp_clk, rxp_dat, rxp_fp, rxp_dl, txp_clk, txp_fp, txp_dl, tx_bit_out} == 8'h00,
        "R10 reset outputs",
        int'({rxp_clk, rxp_dat, rxp_fp, rxp_dl, txp_clk, txp_fp, txp_dl, tx_bit_out}), 0);
    rst = 1'b0;
    tx_chk_en = 1'b1;
    repeat (3) begin
      tx_bit_in = 1'($urandom); exp_tx = tx_bit_in; exp_req = "R8 idle";
      step();
    end
    frame(21'h000000, 1'b1, 1'b1);
    frame(21'h1FFFFF, 1'b1, 1'b0);
    frame(21'h0AAAAA, 1'b0, 1'b1);
    frame(21'h155555, 1'b0, 1'b1);
    frame(21'($urandom), 1'b1, 1'b1);
    for (int f = 0; f < 14; f++)
      frame(21'($urandom), 1'($urandom), 1'($urandom));
    frame(21'h0, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule